// File: doc/BRIEF.md
# Strided Window Address Generator

This block produces a stream of memory addresses for a data path that walks a region of memory without an instruction stream. A sweep starts at a base address and moves by a signed stride on every accepted advance. The sweep stops after a programmed number of addresses, or earlier if the next address would cross a limit address in the direction of travel.

After a sweep that is not the last one, the base and the limit each move by their own signed slide step. The next sweep then begins in the following cycle, so the scan window moves across memory. After a programmed number of sweeps the block returns to idle and gives a one-cycle completion pulse.

Seven configuration registers are written through a simple write port. Their values are copied into working state when `start` is accepted, so software can prepare the next job while a scan is running. The consumer takes an address by raising `adv` while `addr_vld` is high.

Top module: `scan_agen`

## Requirements
- R1: After reset, `addr_vld` and `exec_end` are low and the block is idle.
- R2: A `start` pulse while idle begins a scan: in the next cycle `addr_vld` is high and `addr` equals the base register.
- R3: While `addr_vld` is high inside a sweep, each cycle with `adv` high moves `addr` by the signed stride register (two's complement, AW bits). With `adv` low, `addr` and `addr_vld` hold.
- R4: A sweep emits at most N addresses, where N is the max-count register. A value of 0 counts as 1.
- R5: A sweep also ends after the current address if the next address would be above the limit (positive stride) or below the limit (negative stride). The comparison is done on unwrapped values, so stepping below zero or above the top of the address range counts as crossing. A zero stride is bounded only by the count.
- R6: When a sweep other than the last one ends, the base moves by the base slide register and the limit moves by the limit slide register (both signed). The next sweep presents the new base in the very next cycle, with no idle gap.
- R7: The sweep-count register gives the number of sweeps, with 0 counting as 1. In the cycle after the final address of the final sweep is accepted, `exec_end` is high for exactly one cycle and `addr_vld` is low.
- R8: Register writes during a scan do not change that scan and take effect at the next `start`. A `start` during a scan is ignored.
- R9: Register index map for `cfg_idx`: 0 base, 1 limit, 2 stride, 3 max count, 4 base slide, 5 limit slide, 6 sweep count. Index 7 selects no register. The count registers take the low CW bits of `cfg_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_data | input | AW | Register write data |
| start | input | 1 | Begin a scan when idle |
| adv | input | 1 | Consumer accepts the current address |
| addr | output | AW | Current address |
| addr_vld | output | 1 | Address is valid |
| exec_end | output | 1 | One-cycle pulse when the scan completes |

## Verification
Every result is one register stage after its cause. The first address is present in the cycle after the `start` edge. Each later address, including the first address of a new sweep, follows the edge at which `adv` was sampled high. `exec_end` rises at the edge that consumes the last address and falls at the next edge.

The bench drives inputs just after a rising edge and samples outputs at the same offset after the next edge. This means each sample sees exactly one edge's worth of update. It holds `adv` high during collection, so any bubble between sweeps shows up as a short address list against a sequence that the bench computes itself.

// File: rtl/scan_agen_pkg.sv
package scan_agen_pkg;
   typedef enum logic {ST_IDLE, ST_SCAN} scan_state_t;

   localparam int unsigned IDX_W      = 3;
   localparam int unsigned IDX_BASE   = 0;
   localparam int unsigned IDX_LIMIT  = 1;
   localparam int unsigned IDX_STRIDE = 2;
   localparam int unsigned IDX_MAXCNT = 3;
   localparam int unsigned IDX_BSLIDE = 4;
   localparam int unsigned IDX_LSLIDE = 5;
   localparam int unsigned IDX_SWEEPS = 6;
   localparam int unsigned N_WIDE     = 5;
endpackage

// File: rtl/scan_agen_cfg.sv
module scan_agen_cfg import scan_agen_pkg::*; #(
   parameter int AW = 16,
   parameter int CW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [AW-1:0]    data,
   output logic [AW-1:0]    base,
   output logic [AW-1:0]    limit,
   output logic [AW-1:0]    stride,
   output logic [AW-1:0]    bslide,
   output logic [AW-1:0]    lslide,
   output logic [CW-1:0]    maxcnt,
   output logic [CW-1:0]    sweeps
);
   localparam int unsigned WIDE_IDX [N_WIDE] =
      '{IDX_BASE, IDX_LIMIT, IDX_STRIDE, IDX_BSLIDE, IDX_LSLIDE};

   logic [AW-1:0] wide_q [N_WIDE];
   logic [CW-1:0] maxcnt_q, sweeps_q;

   for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wide_q[g] <= '0;
         else if (wr && (idx == IDX_W'(WIDE_IDX[g])))
            wide_q[g] <= data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         maxcnt_q <= '0;
         sweeps_q <= '0;
      end else if (wr) begin
         if (idx == IDX_W'(IDX_MAXCNT)) maxcnt_q <= data[CW-1:0];
         if (idx == IDX_W'(IDX_SWEEPS)) sweeps_q <= data[CW-1:0];
      end
   end

   assign base   = wide_q[0];
   assign limit  = wide_q[1];
   assign stride = wide_q[2];
   assign bslide = wide_q[3];
   assign lslide = wide_q[4];
   assign maxcnt = maxcnt_q;
   assign sweeps = sweeps_q;
endmodule

// File: rtl/scan_agen_slider.sv
module scan_agen_slider #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] init,
   input  logic [AW-1:0] step,
   input  logic          slide,
   output logic [AW-1:0] value,
   output logic [AW-1:0] nxt
);
   logic [AW-1:0] val_q, step_q;

   assign nxt   = val_q + step_q;
   assign value = val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         step_q <= '0;
      end else if (load) begin
         val_q  <= init;
         step_q <= step;
      end else if (slide) begin
         val_q  <= nxt;
      end
   end
endmodule

// File: rtl/scan_agen_stepper.sv
module scan_agen_stepper #(
   parameter int AW = 16,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic [AW-1:0] stride,
   input  logic [CW-1:0] maxcnt,
   input  logic          restart,
   input  logic [AW-1:0] restart_addr,
   input  logic          step,
   input  logic [AW-1:0] limit,
   output logic [AW-1:0] addr,
   output logic          last
);
   localparam int XW = AW + 2;

   logic [AW-1:0] addr_q, da_q;
   logic [CW-1:0] cnt_q, max_q;
   logic signed [XW-1:0] nxt_x, lim_x;
   logic cnt_done, crosses;

   assign nxt_x = $signed({2'b00, addr_q}) + $signed({{2{da_q[AW-1]}}, da_q});
   assign lim_x = $signed({2'b00, limit});

   always_comb begin
      if (da_q[AW-1])
         crosses = nxt_x < lim_x;
      else if (da_q != '0)
         crosses = nxt_x > lim_x;
      else
         crosses = 1'b0;
   end

   assign cnt_done = cnt_q >= max_q;
   assign last     = cnt_done || crosses;
   assign addr     = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         da_q   <= '0;
         cnt_q  <= '0;
         max_q  <= '0;
      end else if (load) begin
         addr_q <= load_addr;
         da_q   <= stride;
         cnt_q  <= CW'(1);
         max_q  <= (maxcnt == '0) ? CW'(1) : maxcnt;
      end else if (restart) begin
         addr_q <= restart_addr;
         cnt_q  <= CW'(1);
      end else if (step) begin
         addr_q <= nxt_x[AW-1:0];
         cnt_q  <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/scan_agen.sv
module scan_agen import scan_agen_pkg::*; #(
   parameter int AW = 16,
   parameter int CW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [AW-1:0]    cfg_data,
   input  logic             start,
   input  logic             adv,
   output logic [AW-1:0]    addr,
   output logic             addr_vld,
   output logic             exec_end
);
   if (AW < 4) begin : g_bad_aw
      $error("scan_agen: AW must be at least 4");
   end
   if (CW < 1 || CW > AW) begin : g_bad_cw
      $error("scan_agen: CW must lie in 1..AW");
   end

   logic [AW-1:0] cfg_base, cfg_limit, cfg_stride, cfg_bslide, cfg_lslide;
   logic [CW-1:0] cfg_maxcnt, cfg_sweeps;

   scan_state_t   state_q;
   logic [CW-1:0] left_q;
   logic          end_q;
   logic          go, fire, sweep_last, final_sweep, slide;
   logic [AW-1:0] base_cur, base_nxt, lim_cur, lim_nxt;

   scan_agen_cfg #(.AW(AW), .CW(CW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(cfg_idx), .data(cfg_data),
      .base(cfg_base), .limit(cfg_limit), .stride(cfg_stride),
      .bslide(cfg_bslide), .lslide(cfg_lslide),
      .maxcnt(cfg_maxcnt), .sweeps(cfg_sweeps)
   );

   assign go          = start && (state_q == ST_IDLE);
   assign fire        = (state_q == ST_SCAN) && adv;
   assign final_sweep = (left_q == CW'(1));
   assign slide       = fire && sweep_last && !final_sweep;

   scan_agen_slider #(.AW(AW)) u_base (
      .clk(clk), .rst_n(rst_n), .load(go), .init(cfg_base), .step(cfg_bslide),
      .slide(slide), .value(base_cur), .nxt(base_nxt)
   );

   scan_agen_slider #(.AW(AW)) u_limit (
      .clk(clk), .rst_n(rst_n), .load(go), .init(cfg_limit), .step(cfg_lslide),
      .slide(slide), .value(lim_cur), .nxt(lim_nxt)
   );

   scan_agen_stepper #(.AW(AW), .CW(CW)) u_step (
      .clk(clk), .rst_n(rst_n),
      .load(go), .load_addr(cfg_base), .stride(cfg_stride), .maxcnt(cfg_maxcnt),
      .restart(slide), .restart_addr(base_nxt),
      .step(fire && !sweep_last), .limit(lim_cur),
      .addr(addr), .last(sweep_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         end_q   <= 1'b0;
      end else begin
         end_q <= 1'b0;
         if (go) begin
            state_q <= ST_SCAN;
            left_q  <= (cfg_sweeps == '0) ? CW'(1) : cfg_sweeps;
         end else if (fire && sweep_last) begin
            if (final_sweep) begin
               state_q <= ST_IDLE;
               end_q   <= 1'b1;
            end else begin
               left_q <= left_q - CW'(1);
            end
         end
      end
   end

   assign addr_vld = (state_q == ST_SCAN);
   assign exec_end = end_q;
endmodule

// File: rtl/scan_agen_chk.sv
module scan_agen_chk #(
   parameter int AW = 16,
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          adv,
   input logic          addr_vld,
   input logic          exec_end,
   input logic [AW-1:0] addr,
   input logic [AW-1:0] cfg_base,
   input logic [AW-1:0] act_step,
   input logic          sweep_last,
   input logic          slide,
   input logic [AW-1:0] base_nxt,
   input logic [AW-1:0] lim_cur,
   input logic [AW-1:0] lim_nxt,
   input logic [CW-1:0] step_cnt,
   input logic [CW-1:0] max_cnt
);
   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_vld && start) |=> (addr_vld && addr == $past(cfg_base))); // R2
   AST_ADV_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && adv && !sweep_last) |=> (addr_vld && addr == $past(addr) + $past(act_step))); // R3
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && !adv) |=> (addr_vld && $stable(addr))); // R3
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld |-> (step_cnt != '0 && step_cnt <= max_cnt)); // R4
   AST_SLIDE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      slide |=> (addr_vld && addr == $past(base_nxt))); // R6
   AST_SLIDE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      slide |=> (lim_cur == $past(lim_nxt))); // R6
   AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      exec_end |=> !exec_end); // R7
   AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      exec_end |-> !addr_vld); // R7
   AST_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      exec_end |-> $past(addr_vld && adv && sweep_last)); // R7
endmodule

bind scan_agen scan_agen_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
   .addr_vld(addr_vld), .exec_end(exec_end), .addr(addr),
   .cfg_base(cfg_base), .act_step(u_step.da_q), .sweep_last(sweep_last),
   .slide(slide), .base_nxt(base_nxt), .lim_cur(lim_cur), .lim_nxt(lim_nxt),
   .step_cnt(u_step.cnt_q), .max_cnt(u_step.max_q)
);

// File: tb/sim_scan_agen.sv
`timescale 1ns/1ps
module sim_scan_agen;
   localparam int AW = 16;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [2:0]    cfg_idx = '0;
   logic [AW-1:0] cfg_data = '0;
   logic          start = 1'b0;
   logic          adv = 1'b0;
   logic [AW-1:0] addr;
   logic          addr_vld;
   logic          exec_end;

   int n_chk = 0;
   int n_err = 0;
   int exp_a [512];
   int exp_n;
   bit finished = 0;

   always #10 clk = ~clk;

   scan_agen #(.AW(AW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .start(start), .adv(adv),
      .addr(addr), .addr_vld(addr_vld), .exec_end(exec_end)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(int idx, int val);
      cfg_wr = 1'b1; cfg_idx = 3'(idx); cfg_data = AW'(val);
      tick();
      cfg_wr = 1'b0;
   endtask

   task automatic setup(int b, int l, int da, int m, int s, int db, int dl);
      wr(0, b); wr(1, l); wr(2, da); wr(3, m); wr(4, db); wr(5, dl); wr(6, s);
   endtask

   function automatic int sx(int v);
      return (v & 16'h8000) ? ((v & 16'hFFFF) - 65536) : (v & 16'hFFFF);
   endfunction

   task automatic model(int b, int l, int da, int m, int s, int db, int dl);
      int mm = (m & 255) == 0 ? 1 : (m & 255);
      int ss = (s & 255) == 0 ? 1 : (s & 255);
      int d = sx(da);
      exp_n = 0;
      b = b & 16'hFFFF; l = l & 16'hFFFF;
      for (int sw = 0; sw < ss; sw++) begin
         int a = b;
         int k = 0;
         forever begin
            int nx;
            exp_a[exp_n++] = a;
            k++;
            if (k >= mm) break;
            nx = a + d;
            if (d < 0 && nx < l) break;
            if (d > 0 && nx > l) break;
            a = nx;
         end
         b = (b + sx(db)) & 16'hFFFF;
         l = (l + sx(dl)) & 16'hFFFF;
      end
   endtask

   task automatic pulse_start();
      start = 1'b1;
      tick();
      start = 1'b0;
   endtask

   // Collect with adv held high; assumes the scan is already running.
   task automatic collect(string req);
      int got [512];
      int n = 0;
      adv = 1'b1;
      while (addr_vld && n < 512) begin
         got[n++] = int'(addr);
         tick();
      end
      adv = 1'b0;
      chk({req, " count"}, n, exp_n);
      for (int i = 0; i < n && i < exp_n; i++) chk({req, " addr"}, got[i], exp_a[i]);
      chk("R7 exec_end high", int'(exec_end), 1);
      chk("R7 vld low at end", int'(addr_vld), 0);
      tick();
      chk("R7 exec_end one cycle", int'(exec_end), 0);
   endtask

   task automatic run_case(string req, int b, int l, int da, int m, int s, int db, int dl);
      setup(b, l, da, m, s, db, dl);
      model(b, l, da, m, s, db, dl);
      pulse_start();
      chk("R2 vld after start", int'(addr_vld), 1);
      chk("R2 first addr is base", int'(addr), b & 16'hFFFF);
      collect(req);
   endtask

   task automatic t_reset();
      chk("R1 addr_vld reset", int'(addr_vld), 0);
      chk("R1 exec_end reset", int'(exec_end), 0);
   endtask

   task automatic t_count();
      run_case("R4 count bound", 100, 1000, 5, 4, 1, 0, 0);
   endtask

   task automatic t_limit_pos();
      run_case("R5 limit positive", 10, 20, 4, 50, 1, 0, 0);
   endtask

   task automatic t_limit_neg();
      run_case("R5 limit negative", 50, 40, -3, 10, 1, 0, 0);
   endtask

   task automatic t_wrap();
      run_case("R5 below zero", 2, 0, -3, 10, 1, 0, 0);
      chk("R5 single addr", exp_n, 1);
   endtask

   task automatic t_sliders();
      run_case("R6 sliders", 0, 3, 1, 8, 3, 16, 16);
      run_case("R6 negative slide", 200, 190, -5, 6, 2, -50, -50);
   endtask

   task automatic t_zero();
      wr(7, 16'h1234);
      run_case("R4 R9 zero counts", 77, 1000, 2, 0, 0, 0, 0);
   endtask

   task automatic t_stall();
      setup(300, 400, 7, 5, 1, 0, 0);
      pulse_start();
      adv = 1'b0;
      tick(); tick(); tick();
      chk("R3 hold vld", int'(addr_vld), 1);
      chk("R3 hold addr", int'(addr), 300);
      adv = 1'b1;
      tick();
      adv = 1'b0;
      chk("R3 stride step", int'(addr), 307);
      tick();
      chk("R3 hold after step", int'(addr), 307);
      model(307, 400, 7, 4, 1, 0, 0);
      collect("R3 remainder");
   endtask

   task automatic t_frozen();
      setup(1000, 1100, 10, 4, 2, 3, 3);
      pulse_start();
      wr(0, 5000);
      wr(2, 1);
      pulse_start();
      chk("R8 start ignored", int'(addr), 1000);
      model(1000, 1100, 10, 4, 2, 3, 3);
      collect("R8 frozen config");
      model(5000, 1100, 1, 4, 2, 3, 3);
      pulse_start();
      chk("R8 new base used", int'(addr), 5000);
      collect("R8 next start");
   endtask

   initial begin
      tick(); tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_count();
      t_limit_pos();
      t_limit_neg();
      t_wrap();
      t_sliders();
      t_zero();
      t_stall();
      t_frozen();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule